// File: doc/BRIEF.md
# Key-Unlocked Indexed Watchdog Controller

This block is a watchdog timer that the host reaches through two byte-wide I/O ports. One is an index port and the other a data port. The host writes a register number to the index port and then reads or writes that register through the data port. The watchdog configuration is hidden until two things happen. First, the host writes an unlock key to the index port twice in a row. Second, it selects the watchdog control page. A separate key written to the index port hides the configuration again.

Once the block is configured and enabled, an 8-bit down-counter decrements once per second, or once per minute in minutes mode. A parameterised prescaler derives the one-second tick from the clock. Software keeps the system alive by rewriting the counter. Keyboard and mouse event strobes can each be allowed to reload the counter. When the counter runs out, the block drives a reset pulse of fixed length and then leaves the counter at zero.

Top module: `kwdt_ctrl`

## Requirements
- R1: After reset the block is locked, `wdt_rst` is low, and a data-port read returns 0xFF.
- R2: Access opens only after two back-to-back index-port writes of 0x87. Any other write between them, to either port, returns the key sequence to its locked start.
- R3: While locked, data-port reads return 0xFF and data-port writes have no effect. While unlocked with a page other than 0x08 selected, the watchdog registers (0x30, 0xF5, 0xF6, 0xF7) read 0xFF and ignore writes.
- R4: While unlocked, index 0x07 is the page register. It reads back its value, and writing it with 0x08 selects the watchdog page.
- R5: An index-port write of 0xAA locks access again and clears the page register to 0x00.
- R6: On the watchdog page, registers 0x30, 0xF5 and 0xF7 read back all eight bits as last written. Any index that has no register reads 0xFF.
- R7: While enabled in seconds mode, a counter holding N decrements every TICKS_PER_SEC clocks, counted from the enabling write. `wdt_rst` rises N*TICKS_PER_SEC clocks after that write.
- R8: When bit 3 of register 0xF5 is 1 (minutes mode), each decrement takes 60*TICKS_PER_SEC clocks.
- R9: When the counter goes from 1 to 0, `wdt_rst` is high for exactly RST_CYCLES clocks. The counter then stays at 0 and no event reloads it until register 0xF6 is written again.
- R10: Writing register 0xF6 loads the counter and restarts the prescaler. The next decrement comes a full tick later.
- R11: A keyboard strobe while bit 6 of 0xF7 is set, or a mouse strobe while bit 7 is set, reloads the counter with the value last written to 0xF6 and restarts the prescaler. With the bit clear, the strobe has no effect.
- R12: Bit 0 of register 0x30 enables counting. While it is 0 the counter holds its value and no reset is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Read byte; 0xFF unless the data port is being read |
| kbd_evt | input | 1 | Keyboard interrupt event strobe |
| mouse_evt | input | 1 | Mouse interrupt event strobe |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The assertions take three things for granted about the host. It never raises the read and write strobes in the same cycle. Every write lasts exactly one clock. Keyboard and mouse events arrive as single-cycle strobes rather than levels. The stimulus keeps within these limits: each bus operation occupies one cycle, its strobes drop before the next operation, and each event input is raised in a cycle of its own with no bus write alongside it.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_e;

    localparam logic [7:0] KEY_UNLOCK = 8'h87;
    localparam logic [7:0] KEY_RELOCK = 8'hAA;

    localparam logic [7:0] IX_PAGE  = 8'h07;
    localparam logic [7:0] PAGE_WDT = 8'h08;
    localparam logic [7:0] IX_EN    = 8'h30;
    localparam logic [7:0] IX_MODE  = 8'hF5;
    localparam logic [7:0] IX_CNT   = 8'hF6;
    localparam logic [7:0] IX_SRC   = 8'hF7;

    localparam int EN_BIT    = 0;
    localparam int MIN_BIT   = 3;
    localparam int KBD_BIT   = 6;
    localparam int MOUSE_BIT = 7;

    localparam int SEC_PER_MIN = 60;

endpackage

// File: rtl/kwdt_keyseq.sv
module kwdt_keyseq
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       open
);

    typedef struct packed {
        lock_state_e st;
    } ks_t;

    ks_t ks_d, ks_q;

    always_comb begin
        ks_d = ks_q;
        unique case (ks_q.st)
            LK_SHUT: begin
                if (idx_wr && wdata == KEY_UNLOCK) ks_d.st = LK_HALF;
            end
            LK_HALF: begin
                if (idx_wr && wdata == KEY_UNLOCK) ks_d.st = LK_OPEN;
                else if (idx_wr || dat_wr)         ks_d.st = LK_SHUT;
            end
            LK_OPEN: begin
                if (idx_wr && wdata == KEY_RELOCK) ks_d.st = LK_SHUT;
            end
            default: ks_d.st = LK_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ks_q <= '{st: LK_SHUT};
        else        ks_q <= ks_d;
    end

    assign open = (ks_q.st == LK_OPEN);

endmodule

// File: rtl/kwdt_regfile.sv
module kwdt_regfile
    import kwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] cnt_val,
    output logic [7:0] rd_val,
    output logic       wdt_en,
    output logic       minutes,
    output logic       kbd_en,
    output logic       mouse_en,
    output logic       cnt_load
);

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] page;
        logic [7:0] ctl;
        logic [7:0] mode;
        logic [7:0] src;
    } rf_t;

    rf_t rf_d, rf_q;
    logic on_page;

    assign on_page = (rf_q.page == PAGE_WDT);

    always_comb begin
        rf_d     = rf_q;
        cnt_load = 1'b0;
        if (idx_wr) rf_d.idx = wdata;
        if (!open) begin
            rf_d.page = '0;
        end else if (dat_wr) begin
            if (rf_q.idx == IX_PAGE) begin
                rf_d.page = wdata;
            end else if (on_page) begin
                case (rf_q.idx)
                    IX_EN:   rf_d.ctl  = wdata;
                    IX_MODE: rf_d.mode = wdata;
                    IX_SRC:  rf_d.src  = wdata;
                    IX_CNT:  cnt_load  = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_val = 8'hFF;
        if (open) begin
            if (rf_q.idx == IX_PAGE) begin
                rd_val = rf_q.page;
            end else if (on_page) begin
                case (rf_q.idx)
                    IX_EN:   rd_val = rf_q.ctl;
                    IX_MODE: rd_val = rf_q.mode;
                    IX_SRC:  rd_val = rf_q.src;
                    IX_CNT:  rd_val = cnt_val;
                    default: rd_val = 8'hFF;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign wdt_en   = rf_q.ctl[EN_BIT];
    assign minutes  = rf_q.mode[MIN_BIT];
    assign kbd_en   = rf_q.src[KBD_BIT];
    assign mouse_en = rf_q.src[MOUSE_BIT];

endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown
    import kwdt_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int RST_CYCLES    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wdt_en,
    input  logic       minutes,
    input  logic       cnt_load,
    input  logic [7:0] load_val,
    input  logic       kbd_evt,
    input  logic       mouse_evt,
    input  logic       kbd_en,
    input  logic       mouse_en,
    output logic [7:0] cnt_val,
    output logic       evt_reload,
    output logic       wdt_rst
);

    localparam int PRE_W   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int MDIV_W  = $clog2(SEC_PER_MIN);
    localparam int PULSE_W = $clog2(RST_CYCLES + 1);
    localparam logic [PRE_W-1:0]   PRE_LAST   = PRE_W'(TICKS_PER_SEC - 1);
    localparam logic [MDIV_W-1:0]  MDIV_LAST  = MDIV_W'(SEC_PER_MIN - 1);
    localparam logic [PULSE_W-1:0] PULSE_FULL = PULSE_W'(RST_CYCLES);

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [MDIV_W-1:0]  mdiv;
        logic [7:0]         cnt;
        logic [7:0]         reload;
        logic [PULSE_W-1:0] pulse;
    } cd_t;

    cd_t cd_d, cd_q;
    logic sec_tick, unit_tick, restart, expire;

    generate
        if (TICKS_PER_SEC == 1) begin : g_no_prescale
            assign sec_tick = wdt_en;
        end else begin : g_prescale
            assign sec_tick = wdt_en && (cd_q.pre == PRE_LAST);
        end
    endgenerate

    assign unit_tick  = minutes ? (sec_tick && cd_q.mdiv == MDIV_LAST) : sec_tick;
    assign evt_reload = (cd_q.cnt != 8'd0) &&
                        ((kbd_evt && kbd_en) || (mouse_evt && mouse_en));
    assign restart    = cnt_load || evt_reload;
    assign expire     = unit_tick && !restart && (cd_q.cnt == 8'd1);

    always_comb begin
        cd_d = cd_q;

        if (!wdt_en || restart || sec_tick) cd_d.pre = '0;
        else                                cd_d.pre = cd_q.pre + 1'b1;

        if (!wdt_en || restart || !minutes)  cd_d.mdiv = '0;
        else if (sec_tick)                   cd_d.mdiv = (cd_q.mdiv == MDIV_LAST) ? '0 : cd_q.mdiv + 1'b1;

        if (cnt_load) begin
            cd_d.cnt    = load_val;
            cd_d.reload = load_val;
        end else if (evt_reload) begin
            cd_d.cnt = cd_q.reload;
        end else if (unit_tick && cd_q.cnt != 8'd0) begin
            cd_d.cnt = cd_q.cnt - 8'd1;
        end

        if (expire)                  cd_d.pulse = PULSE_FULL;
        else if (cd_q.pulse != '0)   cd_d.pulse = cd_q.pulse - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assign cnt_val = cd_q.cnt;
    assign wdt_rst = (cd_q.pulse != '0);

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
    import kwdt_pkg::*;
#(
    parameter int              ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] IDX_PORT    = ADDR_W'(8'h2E),
    parameter logic [ADDR_W-1:0] DAT_PORT    = ADDR_W'(8'h2F),
    parameter int              TICKS_PER_SEC = 32768,
    parameter int              RST_CYCLES    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              kbd_evt,
    input  logic              mouse_evt,
    output logic              wdt_rst
);

    logic       idx_wr, dat_wr, dat_rd;
    logic       key_open;
    logic [7:0] rd_val, cnt_val;
    logic       wdt_en, minutes, kbd_en, mouse_en, cnt_load, evt_reload;

    assign idx_wr = bus_wr && (bus_addr == IDX_PORT);
    assign dat_wr = bus_wr && (bus_addr == DAT_PORT);
    assign dat_rd = bus_rd && (bus_addr == DAT_PORT);

    kwdt_keyseq u_keyseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .dat_wr (dat_wr),
        .wdata  (bus_wdata),
        .open   (key_open)
    );

    kwdt_regfile u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (key_open),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .wdata    (bus_wdata),
        .cnt_val  (cnt_val),
        .rd_val   (rd_val),
        .wdt_en   (wdt_en),
        .minutes  (minutes),
        .kbd_en   (kbd_en),
        .mouse_en (mouse_en),
        .cnt_load (cnt_load)
    );

    kwdt_countdown #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .RST_CYCLES    (RST_CYCLES)
    ) u_countdown (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdt_en     (wdt_en),
        .minutes    (minutes),
        .cnt_load   (cnt_load),
        .load_val   (bus_wdata),
        .kbd_evt    (kbd_evt),
        .mouse_evt  (mouse_evt),
        .kbd_en     (kbd_en),
        .mouse_en   (mouse_en),
        .cnt_val    (cnt_val),
        .evt_reload (evt_reload),
        .wdt_rst    (wdt_rst)
    );

    assign bus_rdata = dat_rd ? rd_val : 8'hFF;

endmodule

// File: rtl/kwdt_ctrl_chk.sv
module kwdt_ctrl_chk #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] IDX_PORT   = ADDR_W'(8'h2E),
    parameter logic [ADDR_W-1:0] DAT_PORT   = ADDR_W'(8'h2F),
    parameter int                RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              wdt_rst,
    input logic              key_open,
    input logic [7:0]        cnt_val,
    input logic              cnt_load,
    input logic              evt_reload,
    input logic              wdt_en
);

    int unsigned hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run <= 0;
        else if (wdt_rst) hi_run <= hi_run + 1;
        else              hi_run <= 0;
    end

    p_locked_reads_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DAT_PORT && !key_open) |-> bus_rdata == 8'hFF);

    p_unlock_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_open) |-> $past(bus_wr && bus_addr == IDX_PORT && bus_wdata == 8'h87));

    p_step_by_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_load && !evt_reload) |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) - 8'd1));

    p_zero_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val == 8'd0 && !cnt_load) |=> cnt_val == 8'd0);

    p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= RST_CYCLES);

    p_rst_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> $past(wdt_en));

endmodule

bind kwdt_ctrl kwdt_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .IDX_PORT   (IDX_PORT),
    .DAT_PORT   (DAT_PORT),
    .RST_CYCLES (RST_CYCLES)
) u_kwdt_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .wdt_rst    (wdt_rst),
    .key_open   (key_open),
    .cnt_val    (cnt_val),
    .cnt_load   (cnt_load),
    .evt_reload (evt_reload),
    .wdt_en     (wdt_en)
);

// File: tb/kwdt_ctrl_bench.sv
module kwdt_ctrl_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int TPS  = 4;
    localparam int RSTC = 3;
    localparam logic [7:0] IDXP = 8'h2E;
    localparam logic [7:0] DATP = 8'h2F;

    localparam int K_IDX = 0, K_DAT = 1, K_RD = 2, K_IDLE = 3, K_KBD = 4, K_MOUSE = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    kwdt_ctrl #(
        .ADDR_W        (8),
        .IDX_PORT      (IDXP),
        .DAT_PORT      (DATP),
        .TICKS_PER_SEC (TPS),
        .RST_CYCLES    (RSTC)
    ) u_kwdt_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .kbd_evt   (kbd_evt),
        .mouse_evt (mouse_evt),
        .wdt_rst   (wdt_rst)
    );

    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] d;
        logic [7:0] e;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VEC [NV] = '{
        '{3'd2, 8'h00, 8'hFF, 4'd1},   // R1 locked read
        '{3'd1, 8'h55, 8'h00, 4'd3},   // R3 locked write
        '{3'd0, 8'h87, 8'h00, 4'd2},
        '{3'd0, 8'h12, 8'h00, 4'd2},   // R2 broken key
        '{3'd0, 8'h07, 8'h00, 4'd2},
        '{3'd1, 8'h08, 8'h00, 4'd2},
        '{3'd0, 8'h30, 8'h00, 4'd2},
        '{3'd2, 8'h00, 8'hFF, 4'd2},   // R2 still locked
        '{3'd0, 8'h87, 8'h00, 4'd2},
        '{3'd1, 8'h00, 8'h00, 4'd2},   // R2 data write breaks key
        '{3'd0, 8'h87, 8'h00, 4'd2},
        '{3'd0, 8'h07, 8'h00, 4'd2},
        '{3'd1, 8'h08, 8'h00, 4'd2},
        '{3'd2, 8'h00, 8'hFF, 4'd2},   // R2 still locked
        '{3'd0, 8'h87, 8'h00, 4'd2},
        '{3'd0, 8'h87, 8'h00, 4'd2},   // R2 open
        '{3'd0, 8'h30, 8'h00, 4'd3},
        '{3'd2, 8'h00, 8'hFF, 4'd3},   // R3 wrong page
        '{3'd1, 8'h01, 8'h00, 4'd3},   // R3 ignored write
        '{3'd0, 8'h07, 8'h00, 4'd4},
        '{3'd2, 8'h00, 8'h00, 4'd4},   // R4 page reads 0
        '{3'd1, 8'h08, 8'h00, 4'd4},
        '{3'd2, 8'h00, 8'h08, 4'd4},   // R4 page reads 8
        '{3'd0, 8'h30, 8'h00, 4'd3},
        '{3'd2, 8'h00, 8'h00, 4'd3},   // R3 enable write was dropped
        '{3'd1, 8'hA4, 8'h00, 4'd6},
        '{3'd2, 8'h00, 8'hA4, 4'd6},   // R6
        '{3'd0, 8'hF5, 8'h00, 4'd6},
        '{3'd1, 8'h77, 8'h00, 4'd6},
        '{3'd2, 8'h00, 8'h77, 4'd6},   // R6
        '{3'd0, 8'hF7, 8'h00, 4'd6},
        '{3'd1, 8'h3F, 8'h00, 4'd6},
        '{3'd2, 8'h00, 8'h3F, 4'd6},   // R6
        '{3'd0, 8'h5C, 8'h00, 4'd6},
        '{3'd2, 8'h00, 8'hFF, 4'd6},   // R6 no register
        '{3'd0, 8'hF6, 8'h00, 4'd10},
        '{3'd1, 8'h3C, 8'h00, 4'd10},
        '{3'd2, 8'h00, 8'h3C, 4'd10},  // R10 load
        '{3'd0, 8'hAA, 8'h00, 4'd5},
        '{3'd2, 8'h00, 8'hFF, 4'd5},   // R5 relocked
        '{3'd1, 8'h11, 8'h00, 4'd3},   // R3 locked write
        '{3'd0, 8'h87, 8'h00, 4'd5},
        '{3'd0, 8'h87, 8'h00, 4'd5},
        '{3'd0, 8'hF6, 8'h00, 4'd5},
        '{3'd2, 8'h00, 8'hFF, 4'd5},   // R5 page cleared
        '{3'd0, 8'h07, 8'h00, 4'd5},
        '{3'd1, 8'h08, 8'h00, 4'd5},
        '{3'd0, 8'hF6, 8'h00, 4'd12},
        '{3'd2, 8'h00, 8'h3C, 4'd12},  // R12 held while disabled
        '{3'd0, 8'hF5, 8'h00, 4'd8},
        '{3'd1, 8'h00, 8'h00, 4'd8}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at posedge+0.5; occupies exactly one clock; commit happens at the next edge.
    task automatic op(input int kind, input logic [7:0] d, output logic [7:0] r);
        bus_addr  = (kind == K_IDX) ? IDXP : DATP;
        bus_wr    = (kind == K_IDX || kind == K_DAT);
        bus_rd    = (kind == K_RD);
        kbd_evt   = (kind == K_KBD);
        mouse_evt = (kind == K_MOUSE);
        bus_wdata = d;
        #1 r = bus_rdata;
        @(posedge clk);
        #0.5;
        bus_wr = 1'b0; bus_rd = 1'b0; kbd_evt = 1'b0; mouse_evt = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] ix, input logic [7:0] v);
        logic [7:0] r;
        op(K_IDX, ix, r);
        op(K_DAT, v, r);
    endtask

    task automatic idle(input int n);
        logic [7:0] r;
        for (int i = 0; i < n; i++) op(K_IDLE, 8'h00, r);
    endtask

    // Counts idle cycles until wdt_rst is seen high; returns the count and the pulse width.
    task automatic measure(input int lim, output int first, output int width);
        logic [7:0] r;
        first = -1;
        width = 0;
        for (int i = 1; i <= lim; i++) begin
            op(K_IDLE, 8'h00, r);
            if (wdt_rst) begin first = i; break; end
        end
        if (first >= 0) begin
            width = 1;
            for (int i = 0; i < RSTC + 4; i++) begin
                op(K_IDLE, 8'h00, r);
                if (wdt_rst) width++;
                else break;
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int first, width;
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(posedge clk);
        #0.5;
        chk(wdt_rst == 1'b0, "R1 reset output", wdt_rst, 0);

        for (int i = 0; i < NV; i++) begin
            op(int'(VEC[i].kind), VEC[i].d, r);
            if (VEC[i].kind == 3'd2)
                chk(r == VEC[i].e, $sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].e);
        end

        // R11: keyboard reload, mouse ignored then allowed
        wr_reg(8'h30, 8'h00);
        wr_reg(8'hF7, 8'h40);
        wr_reg(8'hF6, 8'h03);
        wr_reg(8'h30, 8'h01);
        op(K_IDX, 8'hF6, r);
        idle(3);
        op(K_RD, 8'h00, r);
        chk(r == 8'h02, "R7 first decrement", r, 8'h02);
        op(K_KBD, 8'h00, r);
        op(K_RD, 8'h00, r);
        chk(r == 8'h03, "R11 keyboard reload", r, 8'h03);
        idle(3);
        op(K_MOUSE, 8'h00, r);
        op(K_RD, 8'h00, r);
        chk(r == 8'h02, "R11 mouse masked", r, 8'h02);
        wr_reg(8'hF7, 8'h80);
        op(K_MOUSE, 8'h00, r);
        op(K_IDX, 8'hF6, r);
        op(K_RD, 8'h00, r);
        chk(r == 8'h03, "R11 mouse reload", r, 8'h03);

        // R7 / R9: seconds expiry
        wr_reg(8'h30, 8'h00);
        wr_reg(8'hF7, 8'h00);
        wr_reg(8'hF6, 8'h03);
        wr_reg(8'h30, 8'h01);
        measure(100, first, width);
        chk(first == 3 * TPS, "R7 expiry time", first, 3 * TPS);
        chk(width == RSTC, "R9 pulse width", width, RSTC);
        op(K_IDX, 8'hF6, r);
        op(K_RD, 8'h00, r);
        chk(r == 8'h00, "R9 counter at zero", r, 0);
        op(K_KBD, 8'h00, r);
        idle(20);
        op(K_RD, 8'h00, r);
        chk(r == 8'h00, "R9 stays at zero", r, 0);
        chk(wdt_rst == 1'b0, "R9 no repeat pulse", wdt_rst, 0);

        // R10: keepalive write restarts countdown
        wr_reg(8'h30, 8'h00);
        wr_reg(8'hF6, 8'h02);
        wr_reg(8'h30, 8'h01);
        op(K_IDX, 8'hF6, r);
        idle(4);
        chk(wdt_rst == 1'b0, "R10 no early reset", wdt_rst, 0);
        op(K_DAT, 8'h02, r);
        measure(100, first, width);
        chk(first == 2 * TPS, "R10 keepalive restart", first, 2 * TPS);
        idle(10);

        // R8: minutes mode
        wr_reg(8'h30, 8'h00);
        wr_reg(8'hF5, 8'h08);
        wr_reg(8'hF6, 8'h01);
        wr_reg(8'h30, 8'h01);
        measure(400, first, width);
        chk(first == 60 * TPS, "R8 minutes expiry", first, 60 * TPS);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule